// File: doc/BRIEF.md
# Temperature Monitor Register File

This block holds the register set of a small temperature monitor and serves it to a byte-oriented serial interface through an 8-bit command pointer. A bit engine outside the block decodes each bus transaction and hands it over as a single-cycle strobe with its bytes. There are four kinds of transaction. A write-byte gives a pointer and a data byte. A send-byte gives only a pointer. A read-byte gives a pointer and returns data. A receive-byte returns data at the pointer already held. The pointer powers up aimed at the remote temperature value, so a host that issues a bare receive-byte straight after reset reads the temperature without first sending a command.

The register set has five entries. The status byte collects sticky flags from the comparators and the diode fault detector. The configuration byte drives the mode and mask fields. Two threshold registers drive the comparators and give a write strobe each. The last entry is a read-only view of the latest temperature result. A read of the status byte clears its sticky flags. The interrupt latch sits outside this block and is not touched by that read.

Top module: `tsense_regfile`

## Requirements
- R1: After reset the command pointer holds 0x01, so a receive-byte issued before any other transaction returns the value on temp_i.
- R2: Write-byte, send-byte and read-byte load the pointer from cmd_i. Receive-byte reads at the held pointer and leaves it unchanged. Pointer map: 0x01 temperature (read-only), 0x02 status (read-only), 0x03 configuration, 0x07 high threshold, 0x08 low threshold.
- R3: For every read-byte or receive-byte, rd_data_o carries the addressed value and rd_valid_o is high in the cycle after the strobe. rd_valid_o is low in every other cycle, and rd_data_o holds its last value.
- R4: The status byte has these fields: bit 0 high-limit flag, bit 1 low-limit flag, bit 2 diode-fault flag, bit 7 converter busy (taken live from busy_i). All other bits are zero. All three flags are zero after reset.
- R5: A one-cycle pulse on set_hi_i, set_lo_i or set_flt_i sets its flag, and the flag stays set until the status byte is read.
- R6: A read of the status byte returns the flags as they stood before the strobe and clears them from the next cycle on. A set pulse in the same cycle as that read leaves its flag set.
- R7: The configuration byte has these fields: bit 7 interrupt mask, bit 6 run/stop, bit 5 thermostat mode, bit 4 alert polarity, bit 3 bias-current select. Bits 2:0 always read as zero. The field outputs follow a write one cycle later, and the byte resets to 0x00.
- R8: The high and low thresholds reset to 0x7F and 0xC9. A write-byte to either one updates thi_o or tlo_o and pulses thi_wr_o or tlo_wr_o for one cycle, both in the cycle after the strobe.
- R9: A write-byte to an unimplemented pointer, or to 0x01 or 0x02, changes no register and pulses no strobe. A read from an unimplemented pointer returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_byte_i | input | 1 | Write-byte strobe (pointer and data) |
| snd_byte_i | input | 1 | Send-byte strobe (pointer only) |
| rd_byte_i | input | 1 | Read-byte strobe (pointer, then data out) |
| rcv_byte_i | input | 1 | Receive-byte strobe (read at held pointer) |
| cmd_i | input | 8 | Command (pointer) byte |
| data_i | input | 8 | Write data byte |
| set_hi_i | input | 1 | High-limit exceeded pulse |
| set_lo_i | input | 1 | Low-limit exceeded pulse |
| set_flt_i | input | 1 | Diode fault pulse |
| busy_i | input | 1 | Converter busy level |
| temp_i | input | 8 | Latest remote temperature |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid |
| cfg_mask_o | output | 1 | Interrupt mask |
| cfg_stop_o | output | 1 | Run/stop standby |
| cfg_tstat_o | output | 1 | Thermostat mode |
| cfg_pol_o | output | 1 | Alert polarity |
| cfg_bias_o | output | 1 | Diode bias-current select |
| thi_o | output | 8 | High threshold |
| tlo_o | output | 8 | Low threshold |
| thi_wr_o | output | 1 | High threshold written pulse |
| tlo_wr_o | output | 1 | Low threshold written pulse |

## Verification
Every result of this block appears exactly one clock after the strobe that causes it. That covers read data with its valid, the configuration fields, the threshold values and their write pulses, and a status clear, which the next status read shows. The reference model in the bench advances once per rising edge on the same inputs the design samples. Its expected outputs are compared one nanosecond after that edge, so each result is checked in the cycle it is due. Because the comparison runs on every clock, a pulse that comes early or late, or an output that changes when nothing was written, is caught as well.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int PTR_W = 8;

    localparam logic [PTR_W-1:0] PTR_TEMP = 8'h01;
    localparam logic [PTR_W-1:0] PTR_STAT = 8'h02;
    localparam logic [PTR_W-1:0] PTR_CFG  = 8'h03;
    localparam logic [PTR_W-1:0] PTR_THI  = 8'h07;
    localparam logic [PTR_W-1:0] PTR_TLO  = 8'h08;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TEMP,
        SEL_STAT,
        SEL_CFG,
        SEL_THI,
        SEL_TLO
    } sel_e;

    function automatic sel_e ptr_decode(input logic [PTR_W-1:0] p);
        case (p)
            PTR_TEMP: return SEL_TEMP;
            PTR_STAT: return SEL_STAT;
            PTR_CFG:  return SEL_CFG;
            PTR_THI:  return SEL_THI;
            PTR_TLO:  return SEL_TLO;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tsense_cmd_dec.sv
module tsense_cmd_dec
    import tsense_pkg::*;
#(
    parameter logic [PTR_W-1:0] PTR_RST = PTR_TEMP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_byte_i,
    input  logic             snd_byte_i,
    input  logic             rd_byte_i,
    input  logic             rcv_byte_i,
    input  logic [PTR_W-1:0] cmd_i,
    output sel_e             acc_sel_o,
    output logic             acc_wr_o,
    output logic             acc_rd_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic [PTR_W-1:0] eff_ptr;

    always_comb begin
        st_d = st_q;
        if (wr_byte_i || snd_byte_i || rd_byte_i) begin
            st_d.ptr = cmd_i;
        end
        // receive-byte uses the held pointer; all others name it directly
        eff_ptr   = rcv_byte_i ? st_q.ptr : cmd_i;
        acc_sel_o = ptr_decode(eff_ptr);
        acc_wr_o  = wr_byte_i;
        acc_rd_o  = rd_byte_i || rcv_byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= PTR_RST;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsense_status.sv
module tsense_status #(
    parameter int DW    = 8,
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_i,
    input  logic             busy_i,
    output logic [DW-1:0]    stat_o
);

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set in the clearing cycle wins over the clear
        st_d.flags = (st_q.flags & ~{NFLAG{clr_i}}) | set_i;
    end

    always_comb begin
        stat_o              = '0;
        stat_o[NFLAG-1:0]   = st_q.flags;
        stat_o[DW-1]        = busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsense_cfg_regs.sv
module tsense_cfg_regs
    import tsense_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          ZLOW    = 3,
    parameter logic [DW-1:0] CFG_RST = '0,
    parameter logic [DW-1:0] THI_RST = 8'h7F,
    parameter logic [DW-1:0] TLO_RST = 8'hC9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  sel_e          sel_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] cfg_o,
    output logic [DW-1:0] thi_o,
    output logic [DW-1:0] tlo_o,
    output logic          thi_wr_o,
    output logic          tlo_wr_o
);

    localparam logic [DW-1:0] CFG_KEEP = {{(DW-ZLOW){1'b1}}, {ZLOW{1'b0}}};

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] thi;
        logic [DW-1:0] tlo;
        logic          thi_wr;
        logic          tlo_wr;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.thi_wr = 1'b0;
        st_d.tlo_wr = 1'b0;
        if (wr_i) begin
            case (sel_i)
                SEL_CFG: st_d.cfg = data_i & CFG_KEEP;
                SEL_THI: begin
                    st_d.thi    = data_i;
                    st_d.thi_wr = 1'b1;
                end
                SEL_TLO: begin
                    st_d.tlo    = data_i;
                    st_d.tlo_wr = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg    <= CFG_RST & CFG_KEEP;
            st_q.thi    <= THI_RST;
            st_q.tlo    <= TLO_RST;
            st_q.thi_wr <= 1'b0;
            st_q.tlo_wr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o    = st_q.cfg;
    assign thi_o    = st_q.thi;
    assign tlo_o    = st_q.tlo;
    assign thi_wr_o = st_q.thi_wr;
    assign tlo_wr_o = st_q.tlo_wr;

endmodule

// File: rtl/tsense_regfile.sv
module tsense_regfile
    import tsense_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NFLAG = 3,
    parameter int ZLOW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_byte_i,
    input  logic             snd_byte_i,
    input  logic             rd_byte_i,
    input  logic             rcv_byte_i,
    input  logic [PTR_W-1:0] cmd_i,
    input  logic [DW-1:0]    data_i,
    input  logic             set_hi_i,
    input  logic             set_lo_i,
    input  logic             set_flt_i,
    input  logic             busy_i,
    input  logic [DW-1:0]    temp_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_valid_o,
    output logic             cfg_mask_o,
    output logic             cfg_stop_o,
    output logic             cfg_tstat_o,
    output logic             cfg_pol_o,
    output logic             cfg_bias_o,
    output logic [DW-1:0]    thi_o,
    output logic [DW-1:0]    tlo_o,
    output logic             thi_wr_o,
    output logic             tlo_wr_o
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } rd_st_t;

    sel_e          acc_sel;
    logic          acc_wr;
    logic          acc_rd;
    logic          stat_clr;
    logic [DW-1:0] stat_byte;
    logic [DW-1:0] cfg_byte;
    rd_st_t        rd_d, rd_q;

    tsense_cmd_dec #(
        .PTR_RST (PTR_TEMP)
    ) cmd_dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_byte_i  (wr_byte_i),
        .snd_byte_i (snd_byte_i),
        .rd_byte_i  (rd_byte_i),
        .rcv_byte_i (rcv_byte_i),
        .cmd_i      (cmd_i),
        .acc_sel_o  (acc_sel),
        .acc_wr_o   (acc_wr),
        .acc_rd_o   (acc_rd)
    );

    assign stat_clr = acc_rd && (acc_sel == SEL_STAT);

    tsense_status #(
        .DW    (DW),
        .NFLAG (NFLAG)
    ) status_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({set_flt_i, set_lo_i, set_hi_i}),
        .clr_i  (stat_clr),
        .busy_i (busy_i),
        .stat_o (stat_byte)
    );

    tsense_cfg_regs #(
        .DW   (DW),
        .ZLOW (ZLOW)
    ) cfg_regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (acc_wr),
        .sel_i    (acc_sel),
        .data_i   (data_i),
        .cfg_o    (cfg_byte),
        .thi_o    (thi_o),
        .tlo_o    (tlo_o),
        .thi_wr_o (thi_wr_o),
        .tlo_wr_o (tlo_wr_o)
    );

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = acc_rd;
        if (acc_rd) begin
            case (acc_sel)
                SEL_TEMP: rd_d.data = temp_i;
                SEL_STAT: rd_d.data = stat_byte;
                SEL_CFG:  rd_d.data = cfg_byte;
                SEL_THI:  rd_d.data = thi_o;
                SEL_TLO:  rd_d.data = tlo_o;
                default:  rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.data <= '0;
            rd_q.vld  <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o   = rd_q.data;
    assign rd_valid_o  = rd_q.vld;
    assign cfg_mask_o  = cfg_byte[DW-1];
    assign cfg_stop_o  = cfg_byte[DW-2];
    assign cfg_tstat_o = cfg_byte[DW-3];
    assign cfg_pol_o   = cfg_byte[DW-4];
    assign cfg_bias_o  = cfg_byte[DW-5];

endmodule

// File: rtl/tsense_regfile_chk.sv
module tsense_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_byte_i,
    input logic       rd_byte_i,
    input logic       rcv_byte_i,
    input logic [7:0] cmd_i,
    input logic [7:0] data_i,
    input logic       set_hi_i,
    input logic       rd_valid_o,
    input logic [7:0] thi_o,
    input logic [7:0] tlo_o,
    input logic       thi_wr_o,
    input logic       tlo_wr_o,
    input logic       stat_clr,
    input logic [7:0] stat_byte,
    input logic [7:0] cfg_byte
);

    // R3
    rd_valid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_i || rcv_byte_i) |=> rd_valid_o);

    // R3
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_byte_i || rcv_byte_i) |=> !rd_valid_o);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_hi_i |=> stat_byte[0]);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !set_hi_i) |=> !stat_byte[0]);

    // R7
    cfg_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_byte[2:0] == 3'b000);

    // R8
    thi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && cmd_i == 8'h07) |=> (thi_wr_o && thi_o == $past(data_i)));

    // R8
    tlo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && cmd_i == 8'h08) |=> (tlo_wr_o && tlo_o == $past(data_i)));

    // R9
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && cmd_i != 8'h03 && cmd_i != 8'h07 && cmd_i != 8'h08)
        |=> ($stable(cfg_byte) && $stable(thi_o) && $stable(tlo_o) && !thi_wr_o && !tlo_wr_o));

endmodule

bind tsense_regfile tsense_regfile_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_byte_i  (wr_byte_i),
    .rd_byte_i  (rd_byte_i),
    .rcv_byte_i (rcv_byte_i),
    .cmd_i      (cmd_i),
    .data_i     (data_i),
    .set_hi_i   (set_hi_i),
    .rd_valid_o (rd_valid_o),
    .thi_o      (thi_o),
    .tlo_o      (tlo_o),
    .thi_wr_o   (thi_wr_o),
    .tlo_wr_o   (tlo_wr_o),
    .stat_clr   (stat_clr),
    .stat_byte  (stat_byte),
    .cfg_byte   (cfg_byte)
);

// File: tb/tsense_regfile_tb_top.sv
module tsense_regfile_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_byte_i = 0, snd_byte_i = 0, rd_byte_i = 0, rcv_byte_i = 0;
    logic [7:0] cmd_i = 0, data_i = 0, temp_i = 8'h00;
    logic       set_hi_i = 0, set_lo_i = 0, set_flt_i = 0, busy_i = 0;
    logic [7:0] rd_data_o, thi_o, tlo_o;
    logic       rd_valid_o, cfg_mask_o, cfg_stop_o, cfg_tstat_o, cfg_pol_o, cfg_bias_o;
    logic       thi_wr_o, tlo_wr_o;

    always #2 clk = ~clk;

    tsense_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_byte_i(wr_byte_i), .snd_byte_i(snd_byte_i),
        .rd_byte_i(rd_byte_i), .rcv_byte_i(rcv_byte_i),
        .cmd_i(cmd_i), .data_i(data_i),
        .set_hi_i(set_hi_i), .set_lo_i(set_lo_i), .set_flt_i(set_flt_i),
        .busy_i(busy_i), .temp_i(temp_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .cfg_mask_o(cfg_mask_o), .cfg_stop_o(cfg_stop_o), .cfg_tstat_o(cfg_tstat_o),
        .cfg_pol_o(cfg_pol_o), .cfg_bias_o(cfg_bias_o),
        .thi_o(thi_o), .tlo_o(tlo_o), .thi_wr_o(thi_wr_o), .tlo_wr_o(tlo_wr_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    int   m_ptr;
    bit   m_hi, m_lo, m_flt;
    int   m_cfg, m_thi, m_tlo;
    int   e_rd;
    bit   e_rv, e_thw, e_tlw;

    task automatic model_reset();
        m_ptr = 1; m_hi = 0; m_lo = 0; m_flt = 0;
        m_cfg = 0; m_thi = 'h7F; m_tlo = 'hC9;
        e_rd = 0; e_rv = 0; e_thw = 0; e_tlw = 0;
    endtask

    task automatic model_step();
        int p;
        p = rcv_byte_i ? m_ptr : int'(cmd_i);
        e_rv = rd_byte_i || rcv_byte_i;
        if (e_rv) begin
            if (p == 1)      e_rd = int'(temp_i);
            else if (p == 2) e_rd = (busy_i ? 128 : 0) + (m_flt ? 4 : 0) + (m_lo ? 2 : 0) + (m_hi ? 1 : 0);
            else if (p == 3) e_rd = m_cfg;
            else if (p == 7) e_rd = m_thi;
            else if (p == 8) e_rd = m_tlo;
            else             e_rd = 0;
        end
        e_thw = wr_byte_i && cmd_i == 8'h07;
        e_tlw = wr_byte_i && cmd_i == 8'h08;
        if (wr_byte_i) begin
            if (cmd_i == 8'h03)      m_cfg = int'(data_i) / 8 * 8;
            else if (cmd_i == 8'h07) m_thi = int'(data_i);
            else if (cmd_i == 8'h08) m_tlo = int'(data_i);
        end
        if (e_rv && p == 2) begin
            m_hi = 0; m_lo = 0; m_flt = 0;
        end
        if (set_hi_i)  m_hi = 1;
        if (set_lo_i)  m_lo = 1;
        if (set_flt_i) m_flt = 1;
        if (wr_byte_i || snd_byte_i || rd_byte_i) m_ptr = int'(cmd_i);
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s (%s): actual 0x%0h expected 0x%0h at %0t", rq, what, tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag,  "rd_valid_o", int'(rd_valid_o), int'(e_rv));
        chk(tag,  "rd_data_o",  int'(rd_data_o),  e_rd);
        chk("R7", "cfg fields",
            int'({cfg_mask_o, cfg_stop_o, cfg_tstat_o, cfg_pol_o, cfg_bias_o}), m_cfg / 8);
        chk("R8", "thi_o",    int'(thi_o),    m_thi);
        chk("R8", "tlo_o",    int'(tlo_o),    m_tlo);
        chk("R8", "thi_wr_o", int'(thi_wr_o), int'(e_thw));
        chk("R8", "tlo_wr_o", int'(tlo_wr_o), int'(e_tlw));
    endtask

    // one clock: inputs already set before the rising edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
        wr_byte_i = 0; snd_byte_i = 0; rd_byte_i = 0; rcv_byte_i = 0;
        set_hi_i = 0; set_lo_i = 0; set_flt_i = 0;
    endtask

    task automatic do_wr(input logic [7:0] c, input logic [7:0] d);
        wr_byte_i = 1; cmd_i = c; data_i = d; cyc();
    endtask
    task automatic do_rd(input logic [7:0] c);
        rd_byte_i = 1; cmd_i = c; cyc();
    endtask
    task automatic do_rcv();
        rcv_byte_i = 1; cyc();
    endtask
    task automatic do_idle();
        cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        tag = "R1";
        chk("R1", "reset rd_valid_o", int'(rd_valid_o), 0);
        chk("R7", "reset cfg", int'({cfg_mask_o, cfg_stop_o, cfg_tstat_o, cfg_pol_o, cfg_bias_o}), 0);
        chk("R8", "reset thi_o", int'(thi_o), 'h7F);
        chk("R8", "reset tlo_o", int'(tlo_o), 'hC9);
        @(negedge clk);
        rst_n = 1;
        temp_i = 8'h5A;
        // R1: bare receive-byte returns temperature
        do_rcv();
        do_idle();
        // R4: busy bit live, flags clear after reset
        tag = "R4";
        busy_i = 1; do_rd(8'h02);
        busy_i = 0; do_idle();
        // R5: sticky high flag
        tag = "R5";
        set_hi_i = 1; do_idle();
        do_idle(); do_idle();
        do_rcv();
        // R6: cleared after read
        tag = "R6";
        do_rcv();
        set_lo_i = 1; do_rcv();
        do_rcv();
        do_rcv();
        // R4: fault flag position, plus all three at once
        tag = "R4";
        set_flt_i = 1; do_idle();
        do_rcv();
        set_hi_i = 1; set_lo_i = 1; set_flt_i = 1; do_idle();
        busy_i = 1; do_rcv(); busy_i = 0;
        do_rcv();
        // R7: configuration
        tag = "R7";
        do_wr(8'h03, 8'hFF);
        do_rd(8'h03);
        do_wr(8'h03, 8'hA8);
        do_rcv();
        do_wr(8'h03, 8'h57);
        do_rcv();
        // R8: thresholds
        tag = "R8";
        do_rd(8'h07);
        do_rd(8'h08);
        do_wr(8'h07, 8'h55);
        do_wr(8'h08, 8'h10);
        do_rd(8'h07);
        do_rd(8'h08);
        // R9: unimplemented and read-only targets
        tag = "R9";
        do_wr(8'h05, 8'hFF);
        do_wr(8'h01, 8'h33);
        do_wr(8'h02, 8'hFF);
        do_wr(8'hFF, 8'h00);
        do_rd(8'h03);
        do_rd(8'h07);
        do_rd(8'h08);
        do_rd(8'h05);
        do_rcv();
        do_rd(8'h00);
        // R2: send-byte and write-byte set pointer, receive keeps it
        tag = "R2";
        snd_byte_i = 1; cmd_i = 8'h01; cyc();
        temp_i = 8'h19; do_rcv();
        temp_i = 8'hE7; do_rcv();
        do_wr(8'h08, 8'h22);
        do_rcv();
        snd_byte_i = 1; cmd_i = 8'h03; cyc();
        do_rcv();
        repeat (3) do_idle();
        done = 1;
        summary();
        $finish;
    end

endmodule